// File: doc/BRIEF.md
# SWD connection sequencer

This block is the host-side controller that takes a Serial Wire Debug target from an unknown wire state to a working debug link. After a `start` pulse it clocks the wake-up patterns onto the debug wire itself. It sends `swclk_o` and `swdio_o` with the output enable held high. It then hands the register accesses of the connection over to a separate transaction engine through a request/response handshake. The engine builds the request header, turns the line around, reads the acknowledge and checks parity.

The `multi_drop` input picks one of two start-up flavours. In single-drop mode the block sends the JTAG-to-SWD switch pattern, a line reset, an identification read and then a sticky-error clear. In multi-drop mode it assumes every target on the shared wire is dormant. It sends the dormant wake-up, a line reset and a target-select write carrying `tsel_value`, which picks one of several targets such as one of two cores. The identification read and the sticky-error clear follow. No target is selected while the select write is in flight, so nothing answers it, and the sequencer ignores whatever acknowledge comes back. Every later access must acknowledge OK, or the sequencer stops with `error` set.

States: `S_IDLE`, `S_DRM_HIGH`, `S_DRM_ALERT`, `S_DRM_GAP`, `S_DRM_ACT` (dormant wake-up), `S_J2S_PRE`, `S_J2S_CODE`, `S_J2S_POST` (JTAG switch), `S_RST_HIGH`, `S_RST_LOW` (line reset), `S_TSEL`, `S_IDRD`, `S_ABORT` (accesses), `S_DONE` and `S_FAIL`.

Transitions:
- `start` in `S_IDLE`, `S_DONE` or `S_FAIL` goes to `S_DRM_HIGH` (multi-drop) or to `S_J2S_PRE` (single-drop).
- Each wire state advances when its segment has been shifted out. The order is `S_DRM_HIGH`→`S_DRM_ALERT`→`S_DRM_GAP`→`S_DRM_ACT`→`S_RST_HIGH` in multi-drop mode and `S_J2S_PRE`→`S_J2S_CODE`→`S_J2S_POST`→`S_RST_HIGH` in single-drop mode.
- `S_RST_HIGH`→`S_RST_LOW`, then `S_RST_LOW`→`S_TSEL` (multi-drop) or `S_IDRD` (single-drop).
- `S_TSEL`→`S_IDRD` on any response.
- `S_IDRD`→`S_ABORT` on an OK response, otherwise `S_FAIL`.
- `S_ABORT`→`S_DONE` on an OK response, otherwise `S_FAIL`.

Top module: `swd_conn_seq`

## Requirements
- R1: After reset `done`, `error`, `swclk_o`, `swdio_oe` and `req_valid` are 0, `idcode` is 0 and `swdio_o` is 1.
- R2: In multi-drop mode the wire carries, in this order and LSB first:
  - 8 ones;
  - the 128-bit alert value 0x19BC0EA2_E3DDAFE9_86852D95_6209F392;
  - 4 zeros;
  - the activation byte 0x1A;
  - then the line reset of R4.
- R3: In single-drop mode the wire carries 56 ones, the 16-bit value 0xE79E LSB first, 56 ones, then the line reset of R4.
- R4: A line reset is 56 ones followed by 2 zeros. No further wire bits follow it.
- R5: Each wire bit spans two clock cycles. `swdio_o` is set while `swclk_o` is low and held while `swclk_o` is high. The bit is taken on the rising edge of `swclk_o`.
- R6: Each access is a request. `req_rnw`=1 means read, and `req_addr` is the 4-bit register byte address.
  - Multi-drop mode issues exactly: a write of `tsel_value` to 0xC, then a read of 0x0, then a write of 0x0000001E to 0x0.
  - Single-drop mode issues the last two only.
  - The wire is idle (`swclk_o`=0, `swdio_oe`=0) while a request is pending.
- R7: Any acknowledge to the target-select write, including non-OK codes such as 3'b111, is ignored and the read of 0x0 follows.
- R8: An acknowledge other than OK (3'b001) to the read or to the clear write sets `error`. No further request is issued, and `error` stays set until the next `start`.
- R9: `idcode` takes `rsp_rdata` from an OK read response. It is 0 after a failed read. `done` rises only after an OK response to the clear write.
- R10: `req_valid`, `req_rnw`, `req_addr` and `req_wdata` are held stable until the cycle in which `rsp_valid` is seen.
- R11: `multi_drop` and `tsel_value` are sampled at `start`. A `start` pulse or a change of these inputs during a run has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a connection (accepted in idle, done or fail) |
| multi_drop | input | 1 | 1 = multi-drop flavour, 0 = single-drop |
| tsel_value | input | 32 | Target-select word for multi-drop |
| swclk_o | output | 1 | Debug clock during wake-up and reset patterns |
| swdio_o | output | 1 | Debug data during wake-up and reset patterns |
| swdio_oe | output | 1 | High while this block drives the wire |
| req_valid | output | 1 | Access request pending |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_addr | output | 4 | Debug-port register byte address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | One-cycle response from the transaction engine |
| rsp_ack | input | 3 | Acknowledge code, OK = 3'b001 |
| rsp_rdata | input | 32 | Read data |
| done | output | 1 | Link established |
| error | output | 1 | Connection failed |
| idcode | output | 32 | Captured identification word |

## Verification
The hardest cases to reach are the acknowledge-dependent branches. One is a target-select write whose acknowledge is garbage but must not stop the run. The others are failures that arrive only at the read or at the final clear. The bench models the transaction engine itself and answers each access with an acknowledge from a per-run plan, after a random latency. Fixed-seed random runs mix OK and non-OK codes on every slot. Directed runs force the no-response pattern on the select write and a restart attempt with flipped mode and select word in the middle of the wake-up.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DRM_HIGH,
        S_DRM_ALERT,
        S_DRM_GAP,
        S_DRM_ACT,
        S_J2S_PRE,
        S_J2S_CODE,
        S_J2S_POST,
        S_RST_HIGH,
        S_RST_LOW,
        S_TSEL,
        S_IDRD,
        S_ABORT,
        S_DONE,
        S_FAIL
    } seq_state_t;

    // Widest single wire segment (the alert pattern)
    localparam int SEG_WIDTH = 128;

    localparam logic [127:0] ALERT_WORD    = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
    localparam logic [7:0]   ACTIVATE_CODE = 8'h1A;
    localparam logic [15:0]  SWITCH_CODE   = 16'hE79E;

    localparam logic [2:0]  ACK_OK      = 3'b001;
    localparam logic [3:0]  ADDR_TSEL   = 4'hC;
    localparam logic [3:0]  ADDR_ID     = 4'h0;
    localparam logic [3:0]  ADDR_ABORT  = 4'h0;
    localparam logic [31:0] ABORT_CLEAR = 32'h0000_001E;

endpackage

// File: rtl/swd_wire_gen.sv
module swd_wire_gen #(
    parameter  int SEG_W = 128,
    localparam int LEN_W = $clog2(SEG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEG_W-1:0] word,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done,
    output logic             swclk_o,
    output logic             swdio_o
);

    logic [SEG_W-1:0] shreg;
    logic [LEN_W-1:0] left;
    logic             phase;
    logic             busy_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            left   <= '0;
            phase  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load && !busy_q) begin
                shreg  <= word;
                left   <= len;
                phase  <= 1'b0;
                busy_q <= (len != '0);
                done_q <= (len == '0);
            end else if (busy_q) begin
                phase <= ~phase;
                if (phase) begin
                    left <= left - 1'b1;
                    if (left == LEN_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        shreg <= shreg >> 1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign swclk_o = phase;
    assign swdio_o = shreg[0];

    // Data must not move while the clock is high
    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swclk_o |-> $stable(swdio_o));

    // A new segment is only requested when the shifter is free
    assert_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/swd_conn_fsm.sv
module swd_conn_fsm
    import swd_seq_pkg::*;
#(
    parameter  int SEG_W       = 128,
    parameter  int WAKE_HIGH   = 8,
    parameter  int GAP_LOW     = 4,
    parameter  int SWITCH_IDLE = 56,
    parameter  int RESET_HIGH  = 56,
    parameter  int RESET_LOW   = 2,
    localparam int LEN_W       = $clog2(SEG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             multi_drop,
    input  logic [31:0]      tsel_value,
    input  logic             gen_done,
    output logic             seg_load,
    output logic [SEG_W-1:0] seg_word,
    output logic [LEN_W-1:0] seg_len,
    output logic             wire_oe,
    output logic             req_valid,
    output logic             req_rnw,
    output logic [3:0]       req_addr,
    output logic [31:0]      req_wdata,
    input  logic             rsp_valid,
    input  logic [2:0]       rsp_ack,
    input  logic [31:0]      rsp_rdata,
    output logic             done,
    output logic             error,
    output logic [31:0]      idcode
);

    seq_state_t  state, nxt;
    logic        launched;
    logic        md_q;
    logic [31:0] tsel_q;
    logic [31:0] idcode_q;
    logic        wire_st;
    logic        adv;
    logic        can_start;

    assign can_start = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            launched <= 1'b0;
            md_q     <= 1'b0;
            tsel_q   <= '0;
            idcode_q <= '0;
        end else begin
            state <= nxt;
            if (state != nxt) begin
                launched <= 1'b0;
            end else if (seg_load) begin
                launched <= 1'b1;
            end
            if (can_start && start) begin
                md_q     <= multi_drop;
                tsel_q   <= tsel_value;
                idcode_q <= '0;
            end
            if (state == S_IDRD && rsp_valid && rsp_ack == ACK_OK) begin
                idcode_q <= rsp_rdata;
            end
        end
    end

    // Next state and segment selection
    always_comb begin
        nxt      = state;
        seg_word = '1;
        seg_len  = '0;
        wire_st  = 1'b0;
        unique case (state)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) nxt = multi_drop ? S_DRM_HIGH : S_J2S_PRE;
            end
            S_DRM_HIGH:  begin wire_st = 1'b1; seg_len = LEN_W'(WAKE_HIGH); end
            S_DRM_ALERT: begin wire_st = 1'b1; seg_word = SEG_W'(ALERT_WORD); seg_len = LEN_W'(128); end
            S_DRM_GAP:   begin wire_st = 1'b1; seg_word = '0; seg_len = LEN_W'(GAP_LOW); end
            S_DRM_ACT:   begin wire_st = 1'b1; seg_word = SEG_W'(ACTIVATE_CODE); seg_len = LEN_W'(8); end
            S_J2S_PRE:   begin wire_st = 1'b1; seg_len = LEN_W'(SWITCH_IDLE); end
            S_J2S_CODE:  begin wire_st = 1'b1; seg_word = SEG_W'(SWITCH_CODE); seg_len = LEN_W'(16); end
            S_J2S_POST:  begin wire_st = 1'b1; seg_len = LEN_W'(SWITCH_IDLE); end
            S_RST_HIGH:  begin wire_st = 1'b1; seg_len = LEN_W'(RESET_HIGH); end
            S_RST_LOW:   begin wire_st = 1'b1; seg_word = '0; seg_len = LEN_W'(RESET_LOW); end
            S_TSEL: begin
                if (rsp_valid) nxt = S_IDRD;
            end
            S_IDRD: begin
                if (rsp_valid) nxt = (rsp_ack == ACK_OK) ? S_ABORT : S_FAIL;
            end
            S_ABORT: begin
                if (rsp_valid) nxt = (rsp_ack == ACK_OK) ? S_DONE : S_FAIL;
            end
            default: nxt = S_IDLE;
        endcase
        adv = wire_st && launched && gen_done;
        if (adv) begin
            unique case (state)
                S_DRM_HIGH:  nxt = S_DRM_ALERT;
                S_DRM_ALERT: nxt = S_DRM_GAP;
                S_DRM_GAP:   nxt = S_DRM_ACT;
                S_J2S_PRE:   nxt = S_J2S_CODE;
                S_J2S_CODE:  nxt = S_J2S_POST;
                S_RST_HIGH:  nxt = S_RST_LOW;
                S_RST_LOW:   nxt = md_q ? S_TSEL : S_IDRD;
                default:     nxt = S_RST_HIGH;
            endcase
        end
        seg_load = wire_st && !launched;
    end

    // Outputs
    always_comb begin
        req_valid = 1'b0;
        req_rnw   = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        unique case (state)
            S_TSEL:  begin req_valid = 1'b1; req_addr = ADDR_TSEL; req_wdata = tsel_q; end
            S_IDRD:  begin req_valid = 1'b1; req_rnw = 1'b1; req_addr = ADDR_ID; end
            S_ABORT: begin req_valid = 1'b1; req_addr = ADDR_ABORT; req_wdata = ABORT_CLEAR; end
            default: ;
        endcase
        wire_oe = wire_st;
        done    = (state == S_DONE);
        error   = (state == S_FAIL);
        idcode  = idcode_q;
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_valid |=> req_valid && $stable(req_rnw)
                                   && $stable(req_addr) && $stable(req_wdata));

    assert_tsel_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_rnw && req_addr == ADDR_TSEL && rsp_valid
            |=> req_valid && req_rnw && !error);

    assert_fail_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(rsp_valid && rsp_ack != ACK_OK));

    assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rsp_valid && rsp_ack == ACK_OK && req_valid
                              && !req_rnw && req_addr == ADDR_ABORT));

endmodule

// File: rtl/swd_conn_seq.sv
module swd_conn_seq
    import swd_seq_pkg::*;
#(
    parameter int WAKE_HIGH   = 8,
    parameter int GAP_LOW     = 4,
    parameter int SWITCH_IDLE = 56,
    parameter int RESET_HIGH  = 56,
    parameter int RESET_LOW   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        multi_drop,
    input  logic [31:0] tsel_value,
    output logic        swclk_o,
    output logic        swdio_o,
    output logic        swdio_oe,
    output logic        req_valid,
    output logic        req_rnw,
    output logic [3:0]  req_addr,
    output logic [31:0] req_wdata,
    input  logic        rsp_valid,
    input  logic [2:0]  rsp_ack,
    input  logic [31:0] rsp_rdata,
    output logic        done,
    output logic        error,
    output logic [31:0] idcode
);

    localparam int SEG_W = SEG_WIDTH;
    localparam int LEN_W = $clog2(SEG_W + 1);

    logic             seg_load;
    logic [SEG_W-1:0] seg_word;
    logic [LEN_W-1:0] seg_len;
    logic             gen_busy;
    logic             gen_done;

    swd_conn_fsm #(
        .SEG_W      (SEG_W),
        .WAKE_HIGH  (WAKE_HIGH),
        .GAP_LOW    (GAP_LOW),
        .SWITCH_IDLE(SWITCH_IDLE),
        .RESET_HIGH (RESET_HIGH),
        .RESET_LOW  (RESET_LOW)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .multi_drop(multi_drop),
        .tsel_value(tsel_value),
        .gen_done  (gen_done),
        .seg_load  (seg_load),
        .seg_word  (seg_word),
        .seg_len   (seg_len),
        .wire_oe   (swdio_oe),
        .req_valid (req_valid),
        .req_rnw   (req_rnw),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .done      (done),
        .error     (error),
        .idcode    (idcode)
    );

    swd_wire_gen #(
        .SEG_W(SEG_W)
    ) i_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (seg_load),
        .word   (seg_word),
        .len    (seg_len),
        .busy   (gen_busy),
        .done   (gen_done),
        .swclk_o(swclk_o),
        .swdio_o(swdio_o)
    );

    // The wire is quiet whenever an access is handed to the engine
    assert_quiet_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !swclk_o && !swdio_oe && !gen_busy);

endmodule

// File: tb/test_swd_conn_seq.sv
`timescale 1ns/1ps
module test_swd_conn_seq;

    localparam logic [2:0] OK = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        multi_drop = 1'b0;
    logic [31:0] tsel_value = '0;
    logic        swclk_o, swdio_o, swdio_oe;
    logic        req_valid, req_rnw;
    logic [3:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_ack = '0;
    logic [31:0] rsp_rdata = '0;
    logic        done, error;
    logic [31:0] idcode;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit got_q[$];
    bit exp_q[$];
    bit cap_en = 0;

    logic [2:0]  plan_tsel, plan_id, plan_abort;
    logic [31:0] id_val;
    int          n_req;
    logic        log_rnw[8];
    logic [3:0]  log_addr[8];
    logic [31:0] log_wdata[8];
    int          dly;

    always #5 clk = ~clk;

    swd_conn_seq i_swd_conn_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .multi_drop(multi_drop),
        .tsel_value(tsel_value), .swclk_o(swclk_o), .swdio_o(swdio_o),
        .swdio_oe(swdio_oe), .req_valid(req_valid), .req_rnw(req_rnw),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .done(done), .error(error),
        .idcode(idcode)
    );

    // Bit capture on the rising debug clock (R5)
    always @(posedge swclk_o) if (cap_en) got_q.push_back(swdio_o);

    // Transaction engine model
    always @(negedge clk) begin
        if (!rst_n) begin
            rsp_valid = 1'b0;
            dly = 0;
        end else if (rsp_valid) begin
            rsp_valid = 1'b0;
        end else if (req_valid) begin
            if (dly == 0) dly = 1 + int'($urandom % 4);
            dly = dly - 1;
            if (dly == 0) begin
                if (n_req < 8) begin
                    log_rnw[n_req]   = req_rnw;
                    log_addr[n_req]  = req_addr;
                    log_wdata[n_req] = req_wdata;
                end
                n_req = n_req + 1;
                if (!req_rnw && req_addr == 4'hC) rsp_ack = plan_tsel;
                else if (req_rnw) rsp_ack = plan_id;
                else rsp_ack = plan_abort;
                rsp_rdata = req_rnw ? id_val : $urandom;
                rsp_valid = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void push_run(input bit v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endfunction

    function automatic void push_word(input logic [127:0] w, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(w[i]);
    endfunction

    function automatic void build_stream(input bit md);
        exp_q.delete();
        if (md) begin
            push_run(1'b1, 8);
            push_word(128'h19BC0EA2_E3DDAFE9_86852D95_6209F392, 128);
            push_run(1'b0, 4);
            push_word(128'h1A, 8);
        end else begin
            push_run(1'b1, 56);
            push_word(128'hE79E, 16);
            push_run(1'b1, 56);
        end
        push_run(1'b1, 56);
        push_run(1'b0, 2);
    endfunction

    function automatic logic [2:0] pick_ack();
        logic [2:0] bad[3] = '{3'b010, 3'b100, 3'b111};
        if ($urandom % 4 != 0) return OK;
        return bad[$urandom % 3];
    endfunction

    task automatic run(input bit md, input logic [31:0] tsel, input logic [2:0] a_t,
                       input logic [2:0] a_i, input logic [2:0] a_a,
                       input logic [31:0] idv, input bit disturb);
        int cnt;
        int mism;
        int exp_n;
        bit exp_ok;
        int base;
        plan_tsel = a_t; plan_id = a_i; plan_abort = a_a; id_val = idv;
        n_req = 0;
        got_q.delete();
        build_stream(md);
        multi_drop = md;
        tsel_value = tsel;
        @(negedge clk);
        start = 1'b1;
        cap_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            multi_drop = ~md;
            tsel_value = ~tsel;
            @(negedge clk);
            start = 1'b0;
        end
        cnt = 0;
        while (!(done || error) && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R8 R9 run ends (timeout)", 32'(cnt < 5000), 32'd1);
        repeat (12) @(negedge clk);
        cap_en = 1'b0;

        // Wire stream
        chk(md ? "R2 R4 stream length" : "R3 R4 stream length", got_q.size(), exp_q.size());
        mism = 0;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (got_q[i] != exp_q[i]) mism++;
        chk(md ? "R2 R5 stream bits wrong" : "R3 R5 stream bits wrong", mism, 0);

        // Access sequence
        exp_ok = (a_i == OK) && (a_a == OK);
        exp_n = (md ? 1 : 0) + 1 + ((a_i == OK) ? 1 : 0);
        chk("R6 R8 request count", n_req, exp_n);
        base = 0;
        if (md && n_req > 0) begin
            chk("R6 tsel write rnw", 32'(log_rnw[0]), 32'd0);
            chk("R6 tsel addr", 32'(log_addr[0]), 32'hC);
            chk(disturb ? "R11 tsel data" : "R6 tsel data", log_wdata[0], tsel);
            base = 1;
        end
        if (n_req > base) begin
            chk(md && a_t != OK ? "R7 id read after ignored ack" : "R6 id read rnw",
                32'(log_rnw[base]), 32'd1);
            chk("R6 id addr", 32'(log_addr[base]), 32'h0);
        end
        if (a_i == OK && n_req > base + 1) begin
            chk("R6 clear rnw", 32'(log_rnw[base+1]), 32'd0);
            chk("R6 clear addr", 32'(log_addr[base+1]), 32'h0);
            chk("R6 clear data", log_wdata[base+1], 32'h1E);
        end
        chk("R9 done", 32'(done), 32'(exp_ok));
        chk("R8 error held", 32'(error), 32'(!exp_ok));
        chk("R9 idcode", idcode, (a_i == OK) ? idv : 32'h0);
        chk("R6 wire released", 32'(swdio_oe), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 done", 32'(done), 0);
        chk("R1 error", 32'(error), 0);
        chk("R1 swclk", 32'(swclk_o), 0);
        chk("R1 swdio", 32'(swdio_o), 1);
        chk("R1 oe", 32'(swdio_oe), 0);
        chk("R1 req_valid", 32'(req_valid), 0);
        chk("R1 idcode", idcode, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", 32'(done | error | req_valid | swclk_o), 0);

        // Directed
        run(1'b1, 32'h0100_2927, OK,     OK,     OK,     32'h0BC1_2477, 1'b0);
        run(1'b1, 32'h1100_2927, 3'b111, OK,     OK,     32'h1234_5678, 1'b0); // R7
        run(1'b0, 32'h0,         OK,     OK,     OK,     32'h2BA0_1477, 1'b0);
        run(1'b0, 32'h0,         OK,     3'b100, OK,     32'hDEAD_BEEF, 1'b0); // R8
        run(1'b1, 32'h0100_2927, 3'b010, OK,     3'b010, 32'hCAFE_0001, 1'b0); // R8
        run(1'b1, 32'hA5A5_0F0F, OK,     OK,     OK,     32'h7777_1111, 1'b1); // R11
        run(1'b0, 32'h5A5A_F0F0, OK,     OK,     OK,     32'h3333_2222, 1'b1); // R11

        // Random
        for (int k = 0; k < 10; k++) begin
            logic [2:0] at, ai, aa;
            bit m;
            m  = 1'($urandom % 2);
            at = ($urandom % 2 == 0) ? OK : 3'($urandom);
            ai = pick_ack();
            aa = pick_ack();
            run(m, $urandom, at, ai, aa, $urandom, 1'b0);
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule